// File: doc/BRIEF.md
# Lockstep Command Decoder with Word-Serial Operand Store

This block is the control and storage slice of one arithmetic unit in an array of identical units. Every unit receives the same 16-bit command stream. A command names an operation and three register indices that are relative to the unit, so one broadcast command touches the same registers in every unit at once. The block checks the command and latches its fields. It then raises a one-cycle launch pulse toward an external modular ALU and holds a busy bit until the ALU reports completion.

Operands live in 21 registers. Each register is kept as a row of words of `WORD_W` bits, and exactly one word moves per access. While busy, the ALU fetches words of the first or second source register and writes words of the destination register, one word per cycle. A host loads starting values and collects results through a port that matches a unit address. Only the low-numbered registers answer on that port. The higher ones are scratch space for the ALU.

Top module: `lockstep_cmd_regfile`

## Requirements
- R1: A command is taken when `cmd_valid` is high and bit 0 (start) is 1. Its fields are: bits [2:1] operation (0 add, 1 subtract, 2 multiply; squaring is a multiply that names the same register twice), bits [6:3] first source, bits [10:7] second source, bits [15:11] destination. An accepted command makes `alu_start` high for exactly the one cycle after the accepting edge, with `alu_op` carrying the operation field.
- R2: A command with bit 0 equal to 0 launches nothing and leaves `err` unchanged.
- R3: `busy` goes high on the edge that accepts a command. It returns to 0 on the edge after an `alu_done` pulse.
- R4: A start command that arrives while `busy` is high is ignored (no launch) and sets `err`. `err` stays 1 until reset.
- R5: A start command with operation 3, a source index of 0, a destination of 0, or a destination above 21 launches nothing and sets `err`.
- R6: While busy, `alu_rd_data` combinationally returns word `alu_word` of the first source (`alu_rd_sel`=0) or the second source (`alu_rd_sel`=1). While idle it reads 0.
- R7: While busy, `alu_wr_en` writes `alu_wr_data` into word `alu_wr_word` of the destination. While idle, `alu_wr_en` has no effect.
- R8: The host port reaches register r (1 ≤ r ≤ 8), word w (w < 7), only when `host_unit` equals `unit_id`. Any other address reads 0 and ignores writes, including hidden registers 9..21 and word index 7.
- R9: Host writes are ignored while `busy` is high.
- R10: After reset `busy`, `err` and `alu_start` are 0 and every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_id | input | UNIT_W | This unit's address on the host port |
| cmd_valid | input | 1 | Broadcast command present |
| cmd_word | input | 16 | Broadcast command |
| busy | output | 1 | Status bit 0: an operation is in flight |
| err | output | 1 | Sticky error flag |
| alu_start | output | 1 | One-cycle launch pulse to the ALU |
| alu_op | output | 2 | Latched operation code |
| alu_rd_sel | input | 1 | 0 reads first source, 1 reads second source |
| alu_word | input | WI | Word index for ALU reads |
| alu_rd_data | output | WORD_W | Word read for the ALU |
| alu_wr_en | input | 1 | ALU word write strobe |
| alu_wr_word | input | WI | Word index for ALU writes |
| alu_wr_data | input | WORD_W | Word written by the ALU |
| alu_done | input | 1 | ALU completion pulse |
| host_wr_en | input | 1 | Host write strobe |
| host_unit | input | UNIT_W | Unit address for host access |
| host_reg | input | 5 | Relative register index for host access |
| host_word | input | WI | Word index for host access |
| host_wr_data | input | WORD_W | Host write data |
| host_rd_data | output | WORD_W | Host read data, 0 when not addressed |

## Verification
The bench uses the defaults: 32-bit words, 7 words per register, 21 registers, 8 host-visible registers and a 4-bit unit address. With 7 words the 3-bit word index has one spare code (7), so out-of-range word access can be driven directly. The 5-bit destination field reaches the indices 22..31 that lie past the register file. The 4-bit source fields reach hidden registers 9..15, so values that only the ALU can see are checked through ALU-side reads.

// File: rtl/lockstep_cmd_regfile.sv
module lockstep_cmd_regfile #(
  parameter int WORD_W    = 32,
  parameter int NWORDS    = 7,
  parameter int NREGS     = 21,
  parameter int HOST_REGS = 8,
  parameter int UNIT_W    = 4,
  localparam int WI = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UNIT_W-1:0] unit_id,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_word,
  output logic              busy,
  output logic              err,
  output logic              alu_start,
  output logic [1:0]        alu_op,
  input  logic              alu_rd_sel,
  input  logic [WI-1:0]     alu_word,
  output logic [WORD_W-1:0] alu_rd_data,
  input  logic              alu_wr_en,
  input  logic [WI-1:0]     alu_wr_word,
  input  logic [WORD_W-1:0] alu_wr_data,
  input  logic              alu_done,
  input  logic              host_wr_en,
  input  logic [UNIT_W-1:0] host_unit,
  input  logic [4:0]        host_reg,
  input  logic [WI-1:0]     host_word,
  input  logic [WORD_W-1:0] host_wr_data,
  output logic [WORD_W-1:0] host_rd_data
);
  localparam logic [WI:0] NW = (WI+1)'(NWORDS);
  localparam logic [4:0]  NR = 5'(NREGS);
  localparam logic [4:0]  HR = 5'(HOST_REGS);

  logic [WORD_W-1:0] mem [NREGS][NWORDS];
  logic [4:0] src_a, src_b, dst;

  wire       go     = cmd_valid & cmd_word[0];
  wire [1:0] f_op   = cmd_word[2:1];
  wire [3:0] f_a    = cmd_word[6:3];
  wire [3:0] f_b    = cmd_word[10:7];
  wire [4:0] f_d    = cmd_word[15:11];
  wire       bad    = (f_op == 2'd3) | (f_a == 4'd0) | (f_b == 4'd0) |
                      (f_d == 5'd0) | (f_d > NR);
  wire       accept = go & ~busy & ~bad;

  wire [4:0] rd_reg  = alu_rd_sel ? src_b : src_a;
  wire       rd_ok   = busy & ({1'b0, alu_word} < NW);
  wire       wr_ok   = busy & alu_wr_en & ({1'b0, alu_wr_word} < NW);
  wire       host_ok = (host_unit == unit_id) & (host_reg != 5'd0) &
                       (host_reg <= HR) & ({1'b0, host_word} < NW);

  assign alu_rd_data  = rd_ok   ? mem[rd_reg - 5'd1][alu_word]    : '0;
  assign host_rd_data = host_ok ? mem[host_reg - 5'd1][host_word] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      err       <= 1'b0;
      alu_start <= 1'b0;
      alu_op    <= 2'd0;
      src_a     <= 5'd1;
      src_b     <= 5'd1;
      dst       <= 5'd1;
    end else begin
      alu_start <= accept;
      if (accept) begin
        busy   <= 1'b1;
        alu_op <= f_op;
        src_a  <= {1'b0, f_a};
        src_b  <= {1'b0, f_b};
        dst    <= f_d;
      end else if (busy && alu_done) begin
        busy <= 1'b0;
      end
      if (go && (busy || bad)) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++)
        for (int w = 0; w < NWORDS; w++)
          mem[r][w] <= '0;
    end else if (wr_ok) begin
      mem[dst - 5'd1][alu_wr_word] <= alu_wr_data;
    end else if (host_ok && host_wr_en && !busy) begin
      mem[host_reg - 5'd1][host_word] <= host_wr_data;
    end
  end
endmodule

// File: rtl/lockstep_cmd_regfile_chk.sv
module lockstep_cmd_regfile_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [15:0]       cmd_word,
  input logic              busy,
  input logic              err,
  input logic              alu_start,
  input logic              alu_done,
  input logic [WORD_W-1:0] alu_rd_data
);
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alu_start |=> !alu_start);

  p_no_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[0]) |=> !alu_start);

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> alu_start);

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && alu_done) |=> !busy);

  p_busy_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_word[0]) |=> (err && !alu_start));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_bad_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[0] && cmd_word[2:1] == 2'd3) |=> (err && !alu_start));

  p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (alu_rd_data == '0));
endmodule

bind lockstep_cmd_regfile lockstep_cmd_regfile_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .busy(busy), .err(err), .alu_start(alu_start), .alu_done(alu_done),
  .alu_rd_data(alu_rd_data)
);

// File: tb/sim_lockstep_cmd_regfile.sv
`timescale 1ns/1ps
module sim_lockstep_cmd_regfile;
  localparam logic [3:0] MY_ID = 4'd5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  unit_id = MY_ID;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        busy, err, alu_start;
  logic [1:0]  alu_op;
  logic        alu_rd_sel = 1'b0;
  logic [2:0]  alu_word = '0;
  logic [31:0] alu_rd_data;
  logic        alu_wr_en = 1'b0;
  logic [2:0]  alu_wr_word = '0;
  logic [31:0] alu_wr_data = '0;
  logic        alu_done = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [3:0]  host_unit = '0;
  logic [4:0]  host_reg = '0;
  logic [2:0]  host_word = '0;
  logic [31:0] host_wr_data = '0;
  logic [31:0] host_rd_data;

  int checks = 0, errors = 0;
  logic [31:0] mdl [0:31][0:7];
  logic exp_busy = 1'b0, exp_err = 1'b0;

  always #2.5 clk = ~clk;

  lockstep_cmd_regfile u0 (
    .clk(clk), .rst_n(rst_n), .unit_id(unit_id), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .busy(busy), .err(err), .alu_start(alu_start),
    .alu_op(alu_op), .alu_rd_sel(alu_rd_sel), .alu_word(alu_word),
    .alu_rd_data(alu_rd_data), .alu_wr_en(alu_wr_en), .alu_wr_word(alu_wr_word),
    .alu_wr_data(alu_wr_data), .alu_done(alu_done), .host_wr_en(host_wr_en),
    .host_unit(host_unit), .host_reg(host_reg), .host_word(host_word),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkcmd(input logic s, input logic [1:0] op,
      input logic [3:0] a, input logic [3:0] b, input logic [4:0] d);
    return {d, b, a, op, s};
  endfunction

  function automatic logic [31:0] alu_fn(input logic [1:0] op, input logic [31:0] x, input logic [31:0] y);
    case (op)
      2'd0: return x + y;
      2'd1: return x - y;
      default: return x * y;
    endcase
  endfunction

  function automatic bit host_vis(input logic [3:0] u, input logic [4:0] r, input logic [2:0] w);
    return (u == MY_ID) && (r >= 5'd1) && (r <= 5'd8) && (w < 3'd7);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; alu_wr_en = 1'b0; alu_done = 1'b0; host_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 32; r++) for (int w = 0; w < 8; w++) mdl[r][w] = '0;
    exp_busy = 1'b0; exp_err = 1'b0;
  endtask

  task automatic send_cmd(input logic [15:0] cw, input string req);
    logic go, bad, launch;
    go  = cw[0];
    bad = (cw[2:1] == 2'd3) || (cw[6:3] == 4'd0) || (cw[10:7] == 4'd0) ||
          (cw[15:11] == 5'd0) || (cw[15:11] > 5'd21);
    launch = go && !exp_busy && !bad;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = cw;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (go && (exp_busy || bad)) exp_err = 1'b1;
    if (launch) exp_busy = 1'b1;
    check({req, " alu_start"}, {31'b0, alu_start}, {31'b0, launch});
    check({req, " busy"}, {31'b0, busy}, {31'b0, exp_busy});
    check({req, " err"}, {31'b0, err}, {31'b0, exp_err});
    if (launch) check({req, " alu_op"}, {30'b0, alu_op}, {30'b0, cw[2:1]});
  endtask

  task automatic host_write(input logic [3:0] u, input logic [4:0] r, input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_unit = u; host_reg = r; host_word = w; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
    if (host_vis(u, r, w) && !exp_busy) mdl[r][w] = d;
  endtask

  task automatic host_check(input logic [3:0] u, input logic [4:0] r, input logic [2:0] w, input string req);
    @(negedge clk);
    host_unit = u; host_reg = r; host_word = w;
    #1;
    check(req, host_rd_data, host_vis(u, r, w) ? mdl[r][w] : 32'h0);
  endtask

  task automatic run_alu(input logic [1:0] op, input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    logic [31:0] res [0:6];
    logic [31:0] ra, rb;
    for (int w = 0; w < 7; w++) begin
      @(negedge clk);
      alu_rd_sel = 1'b0; alu_word = 3'(w); #1 ra = alu_rd_data;
      check("R6 first source word", ra, mdl[a][w]);
      alu_rd_sel = 1'b1; #1 rb = alu_rd_data;
      check("R6 second source word", rb, mdl[b][w]);
      res[w] = alu_fn(op, ra, rb);
    end
    for (int w = 0; w < 7; w++) begin
      @(negedge clk);
      alu_wr_en = 1'b1; alu_wr_word = 3'(w); alu_wr_data = alu_fn(op, mdl[a][w], mdl[b][w]);
    end
    @(negedge clk);
    alu_wr_en = 1'b0;
    for (int w = 0; w < 7; w++) mdl[d][w] = res[w];
    alu_done = 1'b1;
    @(negedge clk);
    alu_done = 1'b0;
    exp_busy = 1'b0;
    check("R3 busy cleared after done", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] op;
    logic [3:0] a, b;
    logic [4:0] d;
    logic [31:0] keep;
    void'($urandom(32'd2024));
    do_reset();
    check("R10 busy after reset", {31'b0, busy}, 32'h0);
    check("R10 err after reset", {31'b0, err}, 32'h0);
    check("R10 alu_start after reset", {31'b0, alu_start}, 32'h0);
    host_check(MY_ID, 5'd1, 3'd0, "R10 word zero after reset");

    for (int r = 1; r <= 8; r++)
      for (int w = 0; w < 7; w++) host_write(MY_ID, 5'(r), 3'(w), $urandom);
    for (int r = 1; r <= 8; r++) host_check(MY_ID, 5'(r), 3'(r % 7), "R8 host readback");
    host_write(4'd3, 5'd2, 3'd1, 32'hDEAD0001);
    host_check(MY_ID, 5'd2, 3'd1, "R8 other unit write ignored");
    host_check(4'd3, 5'd2, 3'd1, "R8 other unit reads zero");
    host_write(MY_ID, 5'd9, 3'd0, 32'hDEAD0002);
    host_check(MY_ID, 5'd9, 3'd0, "R8 hidden register reads zero");
    host_write(MY_ID, 5'd3, 3'd7, 32'hDEAD0003);
    host_check(MY_ID, 5'd3, 3'd7, "R8 word 7 reads zero");
    host_write(MY_ID, 5'd0, 3'd0, 32'hDEAD0004);
    host_check(MY_ID, 5'd1, 3'd0, "R8 register 0 write ignored");

    send_cmd(mkcmd(1'b0, 2'd2, 4'd1, 4'd2, 5'd3), "R2 start bit clear");

    for (int it = 0; it < 40; it++) begin
      op = 2'($urandom_range(0, 2));
      a  = 4'($urandom_range(1, 15));
      b  = (it % 5 == 0) ? a : 4'($urandom_range(1, 15));
      d  = 5'($urandom_range(1, 21));
      if (it == 3) begin op = 2'd2; b = a; end
      send_cmd(mkcmd(1'b1, op, a, b, d), "R1 accepted command");
      if (it == 7) send_cmd(mkcmd(1'b1, 2'd0, 4'd1, 4'd1, 5'd1), "R4 command while busy");
      if (it == 9) begin
        keep = mdl[4][2];
        host_write(MY_ID, 5'd4, 3'd2, 32'hBEEF0009);
        check("R9 host write while busy model", mdl[4][2], keep);
      end
      run_alu(op, {1'b0, a}, {1'b0, b}, d);
      if (d <= 5'd8) host_check(MY_ID, d, 3'($urandom_range(0, 6)), "R7 destination via host");
      if (it == 9) host_check(MY_ID, 5'd4, 3'd2, "R9 busy write ignored");
    end
    check("R4 err sticky", {31'b0, err}, 32'h1);

    do_reset();
    send_cmd(mkcmd(1'b1, 2'd3, 4'd1, 4'd2, 5'd3), "R5 operation 3");
    do_reset();
    send_cmd(mkcmd(1'b1, 2'd0, 4'd0, 4'd2, 5'd3), "R5 first source 0");
    do_reset();
    send_cmd(mkcmd(1'b1, 2'd0, 4'd1, 4'd0, 5'd3), "R5 second source 0");
    do_reset();
    send_cmd(mkcmd(1'b1, 2'd1, 4'd1, 4'd2, 5'd0), "R5 destination 0");
    do_reset();
    send_cmd(mkcmd(1'b1, 2'd1, 4'd1, 4'd2, 5'd22), "R5 destination 22");
    do_reset();
    send_cmd(mkcmd(1'b1, 2'd2, 4'd1, 4'd2, 5'd31), "R5 destination 31");
    send_cmd(mkcmd(1'b1, 2'd0, 4'd2, 4'd3, 5'd21), "R5 destination 21 valid");
    run_alu(2'd0, 5'd2, 5'd3, 5'd21);

    do_reset();
    host_write(MY_ID, 5'd1, 3'd0, 32'h12345678);
    send_cmd(mkcmd(1'b1, 2'd0, 4'd1, 4'd1, 5'd1), "R1 launch for idle write test");
    run_alu(2'd0, 5'd1, 5'd1, 5'd1);
    @(negedge clk);
    alu_wr_en = 1'b1; alu_wr_word = 3'd0; alu_wr_data = 32'hFFFF0000;
    @(negedge clk);
    alu_wr_en = 1'b0;
    host_check(MY_ID, 5'd1, 3'd0, "R7 idle ALU write ignored");
    @(negedge clk);
    alu_rd_sel = 1'b0; alu_word = 3'd0; #1;
    check("R6 idle read is zero", alu_rd_data, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule